// File: doc/BRIEF.md
# SPI Bus Master with Early Data Request

This block drives an SPI bus as its master. It serializes parallel words onto MOSI, captures MISO into a receive word, and generates SCK together with an active-low slave select. A user circuit on a separate parallel clock hands words in with a write strobe. It is told ahead of time when the next word is wanted, and it collects each received word when a valid strobe appears.

The serial engine runs entirely on one fast core clock. A half-period counter produces clock enables, and these step SCK and the shift registers, so no divided clock drives any flip-flop. The SPI mode, the word width, the core cycles per SCK half period and the lead of the early data request are fixed by parameters at build time. A frame keeps going, word after word with no pause, for as long as the user answers each request before the current word's final bit. When the user does not answer, the frame closes by itself.

Top module: `spi_master`

## Requirements
- R1: While reset is high and just after it falls, cs_n is 1, sck sits at its CPOL level, mosi is 0, and next_req and rd_valid are 0.
- R2: A wr_stb while cs_n is high loads wr_data and pulls cs_n low. The first SCK edge follows HALF_DIV core cycles later.
- R3: Bits leave MSB first. A leading edge is sck moving away from its CPOL level. With CPHA=0, mosi takes a new bit at word load and on each trailing edge, and miso is sampled on leading edges. With CPHA=1, mosi changes on leading edges and miso is sampled on trailing edges. mosi never changes on a sampling edge.
- R4: The bits sampled from miso, first bit as MSB, form the word that later appears on rd_data.
- R5: next_req is high for exactly 2 parallel-clock cycles per word. It rises once WORD_W-PREFETCH bits of the word have been sampled, while PREFETCH bits remain.
- R6: A wr_stb that reaches the engine before a word's last SCK edge makes the next word follow at once. cs_n stays low, and every SCK half period stays HALF_DIV core cycles long across the word boundary.
- R7: If no new word is pending at a word's last SCK edge, cs_n rises on that edge and sck rests at its CPOL level.
- R8: rd_data takes the received word a few cycles after the word ends. rd_valid rises exactly 3 parallel-clock cycles after rd_data changes and stays high for exactly 2 cycles. rd_data holds until the next word completes.
- R9: A reset in the middle of a word releases the bus (cs_n high) and leaves rd_data holding the last complete word, with no rd_valid pulse.
- R10: Every SCK half period lasts HALF_DIV core cycles, and sck changes only while cs_n was low in the previous core cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Fast clock of the serial engine |
| clk_par | input | 1 | Clock of the parallel user port |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wr_data | input | WORD_W | Word to transmit |
| wr_stb | input | 1 | One-cycle write strobe (parallel clock) |
| next_req | output | 1 | Two-cycle request for the next word |
| rd_data | output | WORD_W | Last complete received word |
| rd_valid | output | 1 | Two-cycle strobe for a new rd_data |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench streams frames of one, three and two words, answering every request except the last one in each frame. A design that misses a late answer would split a frame and raise cs_n too often. A design that shortens the half period at a word boundary would trip the per-edge spacing check. A slave model returns distinct words with all-ones and all-zeros patterns on MOSI, so a bit-order or sampling-edge mistake shows up as wrong words on either side. A reset in the middle of a word must leave rd_data unchanged with no valid pulse, which catches a receive register that resets or publishes partial data. The spacing between the rd_data update and rd_valid, and between the request and the remaining bit count, is measured cycle for cycle to expose an off-by-one in either delay chain.

// File: rtl/spi_master.sv
module spi_master #(
  parameter int WORD_W   = 8,
  parameter int CPOL     = 0,
  parameter int CPHA     = 0,
  parameter int PREFETCH = 2,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_core,
  input  logic              clk_par,
  input  logic              rst,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_stb,
  output logic              next_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam int EDGE_W    = $clog2(2 * WORD_W);
  localparam int LAST_EDGE = 2 * WORD_W - 1;
  localparam int REQ_EDGE  = 2 * (WORD_W - 1 - PREFETCH);
  localparam bit PH0       = (CPHA == 0);

  // parallel side: capture write, signal by toggle
  logic [WORD_W-1:0] hold_q;
  logic              wr_tgl;
  always_ff @(posedge clk_par) begin
    if (rst) begin
      wr_tgl <= 1'b0;
      hold_q <= '0;
    end else if (wr_stb) begin
      wr_tgl <= ~wr_tgl;
      hold_q <= wr_data;
    end
  end

  // core side
  logic [2:0]        wr_s;
  logic              busy, pend, sck_q, mosi_q, req_tgl, done_tgl;
  logic [WORD_W-1:0] nxt_q, tx_q, rx_q, rx_word;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;

  wire wr_evt = wr_s[2] ^ wr_s[1];
  wire tick   = busy && (div_q == DIV_W'(HALF_DIV - 1));
  wire lead   = ~edge_q[0];
  wire last   = (edge_q == EDGE_W'(LAST_EDGE));
  wire smp    = PH0 ? lead : ~lead;
  wire shift_now = PH0 ? (~lead & ~last) : lead;
  wire have_next = pend | wr_evt;
  wire [WORD_W-1:0] next_word = wr_evt ? hold_q : nxt_q;
  wire start  = ~busy & wr_evt;
  wire reload = tick & last & have_next;
  wire load   = start | reload;
  wire [WORD_W-1:0] rx_nxt = smp ? {rx_q[WORD_W-2:0], miso} : rx_q;

  always_ff @(posedge clk_core) begin
    if (rst) begin
      wr_s     <= '0;
      busy     <= 1'b0;
      pend     <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      req_tgl  <= 1'b0;
      done_tgl <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      nxt_q    <= '0;
    end else begin
      wr_s <= {wr_s[1:0], wr_tgl};
      if (wr_evt) nxt_q <= hold_q;
      if (load) pend <= 1'b0;
      else if (wr_evt) pend <= 1'b1;
      div_q <= (load | tick | ~busy) ? '0 : div_q + 1'b1;
      if (start) busy <= 1'b1;
      else if (tick & last & ~have_next) busy <= 1'b0;
      if (load) edge_q <= '0;
      else if (tick) edge_q <= edge_q + 1'b1;
      if (tick) sck_q <= ~sck_q;
      if (load) begin
        if (PH0) begin
          mosi_q <= next_word[WORD_W-1];
          tx_q   <= {next_word[WORD_W-2:0], 1'b0};
        end else begin
          tx_q   <= next_word;
        end
      end else if (tick & shift_now) begin
        mosi_q <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end
      if (tick) rx_q <= rx_nxt;
      if (tick & last) done_tgl <= ~done_tgl;
      if (tick && edge_q == EDGE_W'(REQ_EDGE)) req_tgl <= ~req_tgl;
    end
  end

  always_ff @(posedge clk_core)
    if (tick & last) rx_word <= rx_nxt;

  assign cs_n = ~busy;
  assign sck  = sck_q ^ 1'(CPOL);
  assign mosi = mosi_q;

  // parallel side: completion and request pulses
  logic [2:0] dn_s, rq_s;
  logic [4:0] v_sh;
  logic [1:0] r_sh;
  wire dn_evt = dn_s[2] ^ dn_s[1];
  wire rq_evt = rq_s[2] ^ rq_s[1];

  always_ff @(posedge clk_par) begin
    if (rst) begin
      dn_s <= '0;
      rq_s <= '0;
      v_sh <= '0;
      r_sh <= '0;
    end else begin
      dn_s <= {dn_s[1:0], done_tgl};
      rq_s <= {rq_s[1:0], req_tgl};
      v_sh <= {v_sh[3:0], dn_evt};
      r_sh <= {r_sh[0], rq_evt};
    end
  end

  always_ff @(posedge clk_par)
    if (dn_evt) rd_data <= rx_word;

  assign rd_valid = v_sh[3] | v_sh[4];
  assign next_req = r_sh[0] | r_sh[1];

endmodule

module spi_master_chk #(
  parameter int WORD_W = 8,
  parameter int CPOL   = 0,
  parameter int CPHA   = 0
) (
  input logic              clk_core,
  input logic              clk_par,
  input logic              rst,
  input logic              sck,
  input logic              cs_n,
  input logic              mosi,
  input logic              rd_valid,
  input logic              next_req,
  input logic [WORD_W-1:0] rd_data
);
  localparam bit IDLE_LVL = 1'(CPOL);
  localparam bit PH0      = (CPHA == 0);

  a_r7_idle_level: assert property (@(posedge clk_core) disable iff (rst)
    cs_n |-> sck == IDLE_LVL);

  a_r10_sck_when_selected: assert property (@(posedge clk_core) disable iff (rst)
    !$stable(sck) |-> !$past(cs_n));

  a_r3_mosi_steady: assert property (@(posedge clk_core) disable iff (rst)
    (!cs_n && !$stable(sck) && ((sck != IDLE_LVL) == PH0)) |-> $stable(mosi));

  a_r8_valid_two: assert property (@(posedge clk_par) disable iff (rst)
    $rose(rd_valid) |=> rd_valid ##1 !rd_valid);

  a_r8_data_held: assert property (@(posedge clk_par) disable iff (rst)
    rd_valid |-> $stable(rd_data));

  a_r5_req_two: assert property (@(posedge clk_par) disable iff (rst)
    $rose(next_req) |=> next_req ##1 !next_req);
endmodule

bind spi_master spi_master_chk #(.WORD_W(WORD_W), .CPOL(CPOL), .CPHA(CPHA)) u_chk (
  .clk_core(clk_core), .clk_par(clk_par), .rst(rst), .sck(sck), .cs_n(cs_n),
  .mosi(mosi), .rd_valid(rd_valid), .next_req(next_req), .rd_data(rd_data));

// File: tb/spi_master_bench.sv
module spi_master_bench;
  localparam int W  = 8;
  localparam int HD = 4;
  localparam int PF = 2;
  localparam logic [7:0] TXV [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};
  localparam int FLEN [3] = '{1, 3, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic wr_stb = 1'b0;
  logic miso = 1'b0;
  logic next_req, rd_valid, sck, cs_n, mosi;
  logic [W-1:0] rd_data;

  always #5 clk = ~clk;

  spi_master #(.WORD_W(W), .CPOL(0), .CPHA(0), .PREFETCH(PF), .HALF_DIV(HD)) u_spi_master (
    .clk_core(clk), .clk_par(clk), .rst(rst), .wr_data(wr_data), .wr_stb(wr_stb),
    .next_req(next_req), .rd_data(rd_data), .rd_valid(rd_valid), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sword(input int k);
    return 8'(k * 43 + 23);
  endfunction

  // slave model and monitors
  int cyc = 0, last_evt = 0, rd_chg_cyc = 0;
  int s_cnt = 0, s_idx = 0, n_slv = 0, n_rd = 0, n_req = 0, cs_rises = 0;
  int vrun = 0, rrun = 0;
  logic [7:0] s_tx = 8'h00, s_rx = 8'h00, prev_rd = 8'h00;
  logic s_reload = 1'b0, prev_sck = 1'b0, prev_cs = 1'b1, prev_valid = 1'b0, prev_req = 1'b0;
  logic [7:0] slv_got [16];
  logic [7:0] rd_got [16];

  always @(negedge clk) begin
    cyc++;
    if (cs_n) begin
      s_cnt = 0;
      s_tx = sword(s_idx);
      s_reload = 1'b0;
    end else if (sck && !prev_sck) begin
      s_rx = {s_rx[6:0], mosi};
      s_cnt++;
      if (s_cnt == W) begin
        slv_got[n_slv] = s_rx;
        n_slv++;
        s_cnt = 0;
        s_idx++;
        s_reload = 1'b1;
      end
    end else if (!sck && prev_sck) begin
      if (s_reload) begin
        s_tx = sword(s_idx);
        s_reload = 1'b0;
      end else s_tx = {s_tx[6:0], 1'b0};
    end
    miso = s_tx[7];

    if (sck != prev_sck) begin
      if (!rst) chk(cyc - last_evt == HD, "R10 half period", cyc - last_evt, HD);
      last_evt = cyc;
    end
    if (!cs_n && prev_cs) last_evt = cyc;
    if (cs_n && !prev_cs && !rst) cs_rises++;

    if (rd_data != prev_rd) rd_chg_cyc = cyc;
    if (rd_valid && !prev_valid) begin
      chk(cyc - rd_chg_cyc == 3, "R8 data-to-valid delay", cyc - rd_chg_cyc, 3);
      rd_got[n_rd] = rd_data;
      n_rd++;
    end
    if (rd_valid) vrun++;
    else if (prev_valid) begin
      chk(vrun == 2, "R8 valid width", vrun, 2);
      vrun = 0;
    end

    if (next_req && !prev_req) begin
      chk(s_cnt == W - PF, "R5 request position", s_cnt, W - PF);
      n_req++;
    end
    if (next_req) rrun++;
    else if (prev_req) begin
      chk(rrun == 2, "R5 request width", rrun, 2);
      rrun = 0;
    end

    prev_sck = sck;
    prev_cs = cs_n;
    prev_rd = rd_data;
    prev_valid = rd_valid;
    prev_req = next_req;
  end

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wi;
    logic [7:0] held;
    int rd_before;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck in reset", sck, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck after reset", sck, 0);
    chk(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
    chk(next_req == 1'b0, "R1 next_req after reset", next_req, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

    // table walk: frames of back-to-back words
    wi = 0;
    for (int f = 0; f < 3; f++) begin
      put(TXV[wi]);
      wi++;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b0, "R2 frame start", cs_n, 0);
      for (int k = 1; k < FLEN[f]; k++) begin
        int r0;
        r0 = n_req;
        while (n_req == r0) @(negedge clk);
        repeat (2) @(negedge clk);
        put(TXV[wi]);
        wi++;
      end
      wait_idle();
      chk(n_slv == wi, "R7 frame ends after last word", n_slv, wi);
      chk(sck == 1'b0, "R7 sck idle at frame end", sck, 0);
      repeat (12) @(negedge clk);
    end

    for (int i = 0; i < 6; i++)
      chk(slv_got[i] == TXV[i], "R3 word on mosi", slv_got[i], TXV[i]);
    chk(n_rd == 6, "R4 received word count", n_rd, 6);
    for (int i = 0; i < 6; i++)
      chk(rd_got[i] == sword(i), "R4 word from miso", rd_got[i], sword(i));
    chk(cs_rises == 3, "R6 no gap inside frames", cs_rises, 3);
    chk(n_req == 6, "R5 one request per word", n_req, 6);

    // R9: reset in the middle of a word
    held = rd_data;
    rd_before = n_rd;
    put(8'hC3);
    while (s_cnt != 3) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R9 bus released by reset", cs_n, 1);
    chk(sck == 1'b0, "R9 sck idle after reset", sck, 0);
    repeat (30) @(negedge clk);
    chk(n_rd == rd_before, "R9 no valid after abort", n_rd, rd_before);
    chk(rd_data == held, "R9 rd_data holds last word", rd_data, held);

    // fresh single-word frame after the abort
    put(8'h96);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b0, "R2 start after reset", cs_n, 0);
    wait_idle();
    repeat (12) @(negedge clk);
    chk(slv_got[n_slv-1] == 8'h96, "R3 word after reset", slv_got[n_slv-1], 8'h96);
    chk(rd_data == sword(6), "R4 word after reset", rd_data, sword(6));
    chk(n_rd == rd_before + 1, "R8 one valid after reset", n_rd, rd_before + 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule